// File: doc/BRIEF.md
# Auto-Ranging Shunt Switch Controller

This block picks one of three current-measurement ranges by driving two shunt-bypass switches. Three comparator flags arrive from the analog front end without any clock relation: the measured signal is below the lower (release) threshold, it is above the upper (engage) threshold, or the supply seen by the device under test has sagged by more than the allowed burden. The block moves up or down one range as soon as a resynchronized flag is seen. Each move starts a hold-off, counted in system clocks, that stops a second move until the measurement has settled. During the hold-off a valid flag stays low, so downstream samples taken in that window can be thrown away.

The sag flag takes a separate path. It presets the range register asynchronously to the highest-current range from any state, skipping the middle range, and it does not wait for a clock or for the hold-off. A host processor can also take direct control of the range, for example during calibration. Both switches are PMOS devices, so their drives are active low.

Top module: `shunt_range_ctrl`

## Requirements
- R1: After reset the range code is 0, both switch drives are high (open) and valid is high.
- R2: The drives follow the range code: code 0 has sw1_n=1, sw2_n=1; code 1 has sw1_n=1, sw2_n=0; code 2 has sw1_n=0, sw2_n=0. sw1 is never closed while sw2 is open.
- R3: While the over-threshold flag is high and no hold-off runs, the range code rises by one on the third rising clock edge after the raw flag rises (two synchronizer flops plus the range register).
- R4: While the under-threshold flag is high and no hold-off runs, the range code falls by one, with the same three-edge latency.
- R5: The range code stays at 2 when the over-threshold flag persists and stays at 0 when the under-threshold flag persists.
- R6: Every change of the range code loads the hold-off counter with holdoff_i. While the counter is nonzero, valid is low and comparator flags cause no step. holdoff_i of 0 allows a step on every clock.
- R7: A high emerg_i forces code 2 at once, with no clock edge. valid is low while emerg_i or its synchronized copy is high, and a full hold-off follows once the synchronized copy falls.
- R8: With host_en_i high, the code takes host_range_i on the next clock edge (a value of 3 is read as 2). Comparator flags are ignored, and a host-driven change starts a hold-off.
- R9: emerg_i overrides host control while it is high.
- R10: Outside emergency and host control, the range code changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_low_i | input | 1 | Raw flag: signal below the release threshold |
| cmp_high_i | input | 1 | Raw flag: signal above the engage threshold |
| emerg_i | input | 1 | Raw flag: supply sag beyond the allowed burden |
| holdoff_i | input | HOLD_W | Settling hold-off length in clocks |
| host_en_i | input | 1 | Host takes control of the range |
| host_range_i | input | 2 | Range requested by the host |
| sw1_n_o | output | 1 | Active-low drive, bypass to smallest shunt |
| sw2_n_o | output | 1 | Active-low drive, bypass to medium shunt |
| range_o | output | 2 | Current range code |
| valid_o | output | 1 | Measurement settled |

## Verification
A held over-threshold flag is applied from the lowest range. This separates the three-edge reaction latency from the hold-off length, and it also checks saturation at the top. A held under-threshold flag is then applied from the top. This checks downward steps and the floor. Running a step sequence with a zero hold-off shows that the counter alone gates the step rate. An emergency flag raised in the middle of a cycle is checked before the next edge, which shows the path is asynchronous and does not pass through the synchronizers. Host requests, including the out-of-range code 3 and an emergency that arrives while the host has control, check the override priorities.

// File: rtl/shunt_range_ctrl.sv
module shunt_range_ctrl #(
  parameter int HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_low_i,
  input  logic              cmp_high_i,
  input  logic              emerg_i,
  input  logic [HOLD_W-1:0] holdoff_i,
  input  logic              host_en_i,
  input  logic [1:0]        host_range_i,
  output logic              sw1_n_o,
  output logic              sw2_n_o,
  output logic [1:0]        range_o,
  output logic              valid_o
);

  localparam logic [1:0] RNG_LO = 2'd0;
  localparam logic [1:0] RNG_HI = 2'd2;

  logic [1:0]        low_sync, high_sync, emerg_sync;
  logic              low_s, high_s, emerg_s;
  logic [1:0]        range_q, range_d;
  logic [HOLD_W-1:0] hold_cnt;
  logic              settled;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      low_sync   <= '0;
      high_sync  <= '0;
      emerg_sync <= '0;
    end else begin
      low_sync   <= {low_sync[0], cmp_low_i};
      high_sync  <= {high_sync[0], cmp_high_i};
      emerg_sync <= {emerg_sync[0], emerg_i};
    end

  assign low_s   = low_sync[1];
  assign high_s  = high_sync[1];
  assign emerg_s = emerg_sync[1];
  assign settled = (hold_cnt == '0);

  always_comb begin
    range_d = range_q;
    if (host_en_i)
      range_d = (host_range_i == 2'd3) ? RNG_HI : host_range_i;
    else if (settled && !emerg_s && !emerg_i) begin
      if (high_s && range_q != RNG_HI)
        range_d = range_q + 2'd1;
      else if (low_s && range_q != RNG_LO)
        range_d = range_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge emerg_i)
    if (!rst_ni)      range_q <= RNG_LO;
    else if (emerg_i) range_q <= RNG_HI;
    else              range_q <= range_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)
      hold_cnt <= '0;
    else if (emerg_s || (!emerg_i && range_d != range_q))
      hold_cnt <= holdoff_i;
    else if (!settled)
      hold_cnt <= hold_cnt - 1'b1;

  assign range_o = range_q;
  assign sw1_n_o = (range_q != RNG_HI);
  assign sw2_n_o = (range_q == RNG_LO);
  assign valid_o = settled && !emerg_s && !emerg_i;

  // R2
  sw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw1_n_o |-> !sw2_n_o);

  // R7
  emerg_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emerg_i |-> (range_o == RNG_HI && !valid_o));

  // R10
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_en_i && !emerg_i && !emerg_s) |=>
      (emerg_i || $past(range_o) == range_o ||
       $past(range_o) + 2'd1 == range_o || $past(range_o) == range_o + 2'd1));

  // R6
  hold_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !host_en_i && !emerg_i) |=> (emerg_i || $stable(range_o)));

  // R6
  change_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!emerg_i && holdoff_i != '0 && !$stable(range_o)) |-> !valid_o);

endmodule

// File: tb/test_shunt_range_ctrl.sv
module test_shunt_range_ctrl;
  localparam int HOLD_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_low = 1'b0, cmp_high = 1'b0, emerg = 1'b0;
  logic [HOLD_W-1:0] holdoff = 16'd4;
  logic              host_en = 1'b0;
  logic [1:0]        host_range = 2'd0;
  logic              sw1_n, sw2_n, valid;
  logic [1:0]        range;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string tag; logic [1:0] r; logic v; } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #4 clk = ~clk;

  shunt_range_ctrl #(.HOLD_W(HOLD_W)) i_shunt_range_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmp_low_i(cmp_low), .cmp_high_i(cmp_high),
    .emerg_i(emerg), .holdoff_i(holdoff), .host_en_i(host_en),
    .host_range_i(host_range), .sw1_n_o(sw1_n), .sw2_n_o(sw2_n),
    .range_o(range), .valid_o(valid));

  task automatic expect_now(string tag, logic [1:0] r, logic v);
    exp_t e;
    e.tag = tag; e.r = r; e.v = v;
    exp_q.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      logic s1e, s2e;
      e = exp_q.pop_front();
      s1e = (e.r != 2'd2);
      s2e = (e.r == 2'd0);
      n_chk++;
      if (range !== e.r || valid !== e.v || sw1_n !== s1e || sw2_n !== s2e) begin
        n_fail++;
        $display("FAIL %s: got range=%0d valid=%0b sw1_n=%0b sw2_n=%0b, exp range=%0d valid=%0b sw1_n=%0b sw2_n=%0b",
                 e.tag, range, valid, sw1_n, sw2_n, e.r, e.v, s1e, s2e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(2);
    expect_now("R1 reset", 2'd0, 1'b1);
    rst_n = 1'b1;
    tick(1);
    expect_now("R1 after release", 2'd0, 1'b1);

    cmp_high = 1'b1;
    tick(2);
    expect_now("R3 no step before third edge", 2'd0, 1'b1);
    tick(1);
    expect_now("R3 R2 step to mid", 2'd1, 1'b0);
    tick(3);
    expect_now("R6 hold-off running", 2'd1, 1'b0);
    tick(1);
    expect_now("R6 hold-off done", 2'd1, 1'b1);
    tick(1);
    expect_now("R3 R2 step to high", 2'd2, 1'b0);
    tick(10);
    expect_now("R5 ceiling", 2'd2, 1'b1);

    cmp_high = 1'b0; cmp_low = 1'b1;
    tick(3);
    expect_now("R4 step down to mid", 2'd1, 1'b0);
    tick(4);
    expect_now("R6 R10 mid held after hold-off", 2'd1, 1'b1);
    tick(1);
    expect_now("R4 step to low", 2'd0, 1'b0);
    holdoff = '0;
    tick(6);
    expect_now("R5 floor", 2'd0, 1'b1);

    cmp_low = 1'b0; cmp_high = 1'b1;
    tick(3);
    expect_now("R6 zero hold-off first step", 2'd1, 1'b1);
    tick(1);
    expect_now("R6 zero hold-off back-to-back", 2'd2, 1'b1);
    cmp_high = 1'b0; cmp_low = 1'b1;
    tick(5);
    expect_now("R4 back to low", 2'd0, 1'b1);
    cmp_low = 1'b0;
    holdoff = 16'd4;
    tick(3);

    #2 emerg = 1'b1;
    #1 expect_now("R7 async jump low to high", 2'd2, 1'b0);
    tick(3);
    emerg = 1'b0;
    tick(5);
    expect_now("R7 hold-off after release", 2'd2, 1'b0);
    tick(1);
    expect_now("R7 settled after release", 2'd2, 1'b1);

    host_en = 1'b1; host_range = 2'd1;
    tick(1);
    expect_now("R8 host selects mid", 2'd1, 1'b0);
    host_range = 2'd3;
    tick(1);
    expect_now("R8 host code 3 reads as high", 2'd2, 1'b0);
    cmp_low = 1'b1;
    tick(8);
    expect_now("R8 comparators ignored", 2'd2, 1'b1);
    host_range = 2'd0;
    tick(1);
    expect_now("R8 host selects low", 2'd0, 1'b0);
    tick(5);
    #2 emerg = 1'b1;
    #1 expect_now("R9 emergency over host", 2'd2, 1'b0);
    @(negedge clk);
    emerg = 1'b0;
    tick(1);
    expect_now("R9 host resumes after emergency", 2'd0, 1'b0);
    host_en = 1'b0; cmp_low = 1'b0;
    tick(10);
    expect_now("R1 idle after host", 2'd0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule